// File: doc/BRIEF.md
# Two-Level Hardware Page Table Walker

This block resolves a virtual page number into a physical page number when the translation buffer misses. It holds a root pointer to the active process's first-level table, reads one word from each of two table levels in untranslated physical memory, and returns either the leaf's physical page number with its permission bits or a fault that names the level at which the walk stopped. A 32-bit virtual address is split 10/10/12: the upper ten bits of the 20-bit virtual page number index the first-level table, the lower ten bits index the second-level table, and the 12-bit page offset is not seen by the walker.

The walker accepts one miss at a time. It has a single-word read port with a request/accept handshake and a response strobe that can come any number of cycles later. Exactly one read is in flight at a time. The root pointer can be rewritten only while the walker is idle. The result is shown for a single cycle.

Top module: `pt_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready` is 1, and `done` and `mem_req_valid` are 0.
- R2: The first read goes to address root + 4 × L1 index. The root is the last value written while idle, with its two low bits cleared. The L1 index is `req_vpn[19:10]`, which is virtual address bits 31:22.
- R3: An entry is valid when its bit 0 is 1. After a valid first-level entry, the second read goes to {entry[31:12], `req_vpn[9:0]`, 2'b00}.
- R4: An entry's layout is valid in bit 0, read in bit 1, write in bit 2, dirty in bit 3, and page number in bits 31:12. On success `done_ppn` is leaf[31:12], `done_perm` is leaf[3:1] (= {dirty, write, read}), and `done_fault` is 0.
- R5: If the first-level entry is invalid (bit 0 clear), the walk ends after one read. It reports `done_fault`=1 and `done_fault_lvl`=0, with `done_ppn` and `done_perm` both 0.
- R6: If the second-level entry is invalid, the walk reports `done_fault`=1 and `done_fault_lvl`=1, with `done_ppn` and `done_perm` both 0.
- R7: At most one read is in flight. A request that is not accepted holds its valid and its address until it is accepted. No new request is made until the previous response has come back.
- R8: `done` is high for exactly one cycle. `req_ready` is low from the cycle after acceptance through the `done` cycle, and high again in the next cycle.
- R9: A root write while the walker is busy (including the `done` cycle) is ignored. A write while idle takes effect, and it is used by a walk accepted in the same cycle.
- R10: Any response delay of zero or more cycles after acceptance gives the same result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_we | input | 1 | Root pointer write strobe |
| base_wdata | input | 32 | Root pointer physical address |
| req_valid | input | 1 | Miss request |
| req_vpn | input | 20 | Virtual page number to translate |
| req_ready | output | 1 | Walker idle, request accepted |
| mem_req_valid | output | 1 | Table read request |
| mem_req_addr | output | 32 | Physical word address of the entry |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 32 | Entry read from memory |
| done | output | 1 | One-cycle result strobe |
| done_ppn | output | 20 | Resolved physical page number |
| done_perm | output | 3 | {dirty, write, read} of the leaf |
| done_fault | output | 1 | Walk stopped at an invalid entry |
| done_fault_lvl | output | 1 | 0: first level, 1: second level |

## Verification
The hardest case to reach is a root write that lands while a walk is in flight. A later walk only exposes it if that walk's addresses would move with the root. The bench pokes the root mid-walk and then runs further walks with no legal rewrite in between, checking each request address against the root the bench expects. Each table entry is generated from a hash of its address, and a per-walk override forces either level to be invalid. The memory model varies acceptance stalls and response delays at random, so both fault levels are reached and the hold-until-accepted rule is exercised under back-pressure.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int PA_W  = 32,
  parameter int OFF_W = 12,
  parameter int IDX_W = 10,
  localparam int VPN_W = PA_W - OFF_W,
  localparam int PPN_W = PA_W - OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             base_we,
  input  logic [PA_W-1:0]  base_wdata,
  input  logic             req_valid,
  input  logic [VPN_W-1:0] req_vpn,
  output logic             req_ready,
  output logic             mem_req_valid,
  output logic [PA_W-1:0]  mem_req_addr,
  input  logic             mem_req_ready,
  input  logic             mem_rsp_valid,
  input  logic [PA_W-1:0]  mem_rsp_data,
  output logic             done,
  output logic [PPN_W-1:0] done_ppn,
  output logic [2:0]       done_perm,
  output logic             done_fault,
  output logic             done_fault_lvl
);
  localparam int HI_W = VPN_W - IDX_W;

  typedef enum logic [2:0] {
    S_IDLE, S_L1_REQ, S_L1_WAIT, S_L2_REQ, S_L2_WAIT, S_DONE, S_FAULT
  } walk_st_t;

  walk_st_t         st;
  logic [PA_W-1:0]  root_q;
  logic [VPN_W-1:0] vpn_q;
  logic [PPN_W-1:0] ptr_q;
  logic [PPN_W-1:0] res_ppn;
  logic [2:0]       res_perm;
  logic             res_lvl;
  logic [PA_W-1:0]  l1_addr, l2_addr;
  logic             unused_rsp_bits;

  assign unused_rsp_bits = ^mem_rsp_data[OFF_W-1:4];

  assign l1_addr = root_q + {{(PA_W-HI_W-2){1'b0}}, vpn_q[VPN_W-1:IDX_W], 2'b00};
  assign l2_addr = {ptr_q, vpn_q[IDX_W-1:0], {(OFF_W-IDX_W){1'b0}}};

  assign req_ready      = (st == S_IDLE);
  assign mem_req_valid  = (st == S_L1_REQ) || (st == S_L2_REQ);
  assign mem_req_addr   = (st == S_L2_REQ) ? l2_addr : l1_addr;
  assign done           = (st == S_DONE) || (st == S_FAULT);
  assign done_fault     = (st == S_FAULT);
  assign done_fault_lvl = (st == S_FAULT) && res_lvl;
  assign done_ppn       = (st == S_DONE) ? res_ppn  : '0;
  assign done_perm      = (st == S_DONE) ? res_perm : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      root_q <= '0;
    end else if (base_we && st == S_IDLE) begin
      root_q <= {base_wdata[PA_W-1:2], 2'b00};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      vpn_q    <= '0;
      ptr_q    <= '0;
      res_ppn  <= '0;
      res_perm <= '0;
      res_lvl  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          vpn_q <= req_vpn;
          st    <= S_L1_REQ;
        end
        S_L1_REQ: if (mem_req_ready) st <= S_L1_WAIT;
        S_L1_WAIT: if (mem_rsp_valid) begin
          if (mem_rsp_data[0]) begin
            ptr_q <= mem_rsp_data[PA_W-1:OFF_W];
            st    <= S_L2_REQ;
          end else begin
            res_lvl <= 1'b0;
            st      <= S_FAULT;
          end
        end
        S_L2_REQ: if (mem_req_ready) st <= S_L2_WAIT;
        S_L2_WAIT: if (mem_rsp_valid) begin
          if (mem_rsp_data[0]) begin
            res_ppn  <= mem_rsp_data[PA_W-1:OFF_W];
            res_perm <= mem_rsp_data[3:1];
            st       <= S_DONE;
          end else begin
            res_lvl <= 1'b1;
            st      <= S_FAULT;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r1_reset_idle: assert property (@(posedge clk)
    $fell(rst_n) |=> req_ready && !done && !mem_req_valid);

  a_r2_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_addr[1:0] == 2'b00);

  a_r5_l1_fault_origin: assert property (@(posedge clk) disable iff (!rst_n)
    done_fault && !done_fault_lvl |-> $past(st) == S_L1_WAIT);

  a_r7_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  a_r7_no_req_while_waiting: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready |=> !mem_req_valid);

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && req_ready);

  a_r9_root_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> $stable(root_q));
endmodule

// File: tb/pt_walker_tb_top.sv
module pt_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_we = 1'b0;
  logic [31:0] base_wdata = '0;
  logic        req_valid = 1'b0;
  logic [19:0] req_vpn = '0;
  logic        req_ready;
  logic        mem_req_valid;
  logic [31:0] mem_req_addr;
  logic        mem_req_ready;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic        done;
  logic [19:0] done_ppn;
  logic [2:0]  done_perm;
  logic        done_fault;
  logic        done_fault_lvl;

  always #5 clk = ~clk;

  pt_walker dut_i (
    .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_wdata(base_wdata),
    .req_valid(req_valid), .req_vpn(req_vpn), .req_ready(req_ready),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .done(done), .done_ppn(done_ppn),
    .done_perm(done_perm), .done_fault(done_fault), .done_fault_lvl(done_fault_lvl)
  );

  int          n_chk = 0;
  int          n_bad = 0;
  logic [31:0] root_cur = '0;
  logic [31:0] salt = 32'h1234_5678;
  int          force_lvl = 0;
  int          lvl_cnt = 0;
  logic [31:0] exp_a [2];

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", rq, act, expv, $time);
    end
  endtask

  function automatic logic [31:0] mix(input logic [31:0] a);
    logic [31:0] x;
    x = a ^ salt;
    x = x ^ (x >> 16);
    x = x * 32'h7feb352d;
    x = x ^ (x >> 15);
    x = x * 32'h846ca68b;
    x = x ^ (x >> 16);
    return x;
  endfunction

  function automatic logic [31:0] pte_at(input logic [31:0] a, input int lvl);
    logic [31:0] w;
    w = mix(a);
    if (force_lvl == lvl + 1) w[0] = 1'b0;
    else if (force_lvl == 3 || (force_lvl == 2 && lvl == 0)) w[0] = 1'b1;
    return w;
  endfunction

  // memory model: random accept stalls and response delays (R7, R10)
  bit          acc = 0;
  bit          hold_prev = 0;
  logic [31:0] hold_addr = '0;
  logic [31:0] paddr = '0;
  int          dly = 0;
  initial begin
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      mem_req_ready = 1'b0;
      if (acc) begin
        if (dly == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = pte_at(paddr, lvl_cnt - 1);
          acc = 0;
        end else dly--;
      end
      if (hold_prev)
        chk(mem_req_valid && mem_req_addr == hold_addr, "R7 hold", mem_req_addr, hold_addr);
      hold_prev = 0;
      if (mem_req_valid && rst_n) begin
        if (acc || mem_rsp_valid) begin
          chk(0, "R7 outstanding", mem_req_addr, 32'h0);
        end else if ($urandom % 3 != 0) begin
          mem_req_ready = 1'b1;
          acc   = 1;
          paddr = mem_req_addr;
          dly   = $urandom % 5;
          if (lvl_cnt < 2)
            chk(mem_req_addr == exp_a[lvl_cnt], lvl_cnt == 0 ? "R2 l1 addr" : "R3 l2 addr",
                mem_req_addr, exp_a[lvl_cnt]);
          lvl_cnt++;
        end else begin
          hold_prev = 1;
          hold_addr = mem_req_addr;
        end
      end
    end
  end

  task automatic set_base(input logic [31:0] v);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    base_we = 1'b1; base_wdata = v;
    @(negedge clk);
    base_we = 1'b0;
    root_cur = {v[31:2], 2'b00};
  endtask

  task automatic walk(input logic [19:0] vpn, input int frc, input bit same_base,
                      input logic [31:0] bval, input bit poke);
    logic [31:0] e1, e2;
    bit          ef, el;
    logic [19:0] eppn;
    logic [2:0]  eperm;
    int          ereq, n;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    force_lvl = frc;
    lvl_cnt = 0;
    req_valid = 1'b1; req_vpn = vpn;
    if (same_base) begin
      base_we = 1'b1; base_wdata = bval;
      root_cur = {bval[31:2], 2'b00};
    end
    exp_a[0] = root_cur + {20'd0, vpn[19:10], 2'b00};
    e1 = pte_at(exp_a[0], 0);
    exp_a[1] = {e1[31:12], vpn[9:0], 2'b00};
    e2 = pte_at(exp_a[1], 1);
    if (!e1[0]) begin ef = 1; el = 0; eppn = '0; eperm = '0; ereq = 1; end
    else if (!e2[0]) begin ef = 1; el = 1; eppn = '0; eperm = '0; ereq = 2; end
    else begin ef = 0; el = 0; eppn = e2[31:12]; eperm = e2[3:1]; ereq = 2; end
    @(negedge clk);
    req_valid = 1'b0; base_we = 1'b0;
    chk(!req_ready, "R8 busy", {31'd0, req_ready}, 32'd0);
    if (poke) begin
      base_we = 1'b1; base_wdata = $urandom;
      @(negedge clk);
      base_we = 1'b0;
    end
    n = 0;
    while (!done && n < 200) begin @(negedge clk); n++; end
    chk(done, "R10 completes", {31'd0, done}, 32'd1);
    chk(done_fault == ef, ef ? (el ? "R6 fault" : "R5 fault") : "R4 fault", {31'd0, done_fault}, {31'd0, ef});
    chk(done_fault_lvl == el, el ? "R6 level" : "R5 level", {31'd0, done_fault_lvl}, {31'd0, el});
    chk(done_ppn == eppn, "R4 ppn", {12'd0, done_ppn}, {12'd0, eppn});
    chk(done_perm == eperm, "R4 perm", {29'd0, done_perm}, {29'd0, eperm});
    chk(lvl_cnt == ereq, "R5 read count", lvl_cnt, ereq);
    @(negedge clk);
    chk(!done && req_ready, "R8 pulse", {30'd0, done, req_ready}, 32'd1);
  endtask

  initial begin
    void'($urandom(32'd4750));
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !done && !mem_req_valid, "R1 reset",
            {29'd0, req_ready, done, mem_req_valid}, 32'h4);
        set_base(32'h0004_0003);                        // R9 idle write, low bits dropped
        walk(20'h00000, 3, 0, 0, 0);                    // R4 success, min indices
        walk(20'hFFFFF, 3, 0, 0, 0);                    // R2 R3 max indices
        walk(20'h12345, 1, 0, 0, 0);                    // R5
        walk(20'h54321, 2, 0, 0, 0);                    // R6
        walk(20'hABCDE, 3, 1, 32'h0123_4FFF, 0);        // R9 same-cycle write
        walk(20'h0F0F0, 3, 0, 0, 1);                    // R9 busy write ignored
        walk(20'h0F0F1, 3, 0, 0, 0);                    // R9 root still old
        for (int i = 0; i < 400; i++) begin
          if ($urandom % 10 == 0) set_base($urandom);
          walk($urandom, ($urandom % 4 == 0) ? 0 : $urandom % 4, $urandom % 8 == 0,
               $urandom, $urandom % 5 == 0);
        end
      end
      begin
        repeat (150000) @(negedge clk);
        chk(0, "watchdog", 32'd0, 32'd1);
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule